// File: doc/BRIEF.md
# Byte-Bus Parallel I/O Unit with Handshake Status

This block gives a processor three parallel ports on a byte-wide register bus. Two 8-bit ports can each be set as input or output. A third, 6-bit port is a plain input, a plain output, or the handshake wiring for the two wide ports. A command register selects these modes. Reading the same address returns a status byte that holds both ports' handshake flags and a flag from an external timer.

While the narrow port is in handshake mode, each wide port runs a strobed protocol. In input mode, a falling peripheral strobe captures the pin data into a holding register and marks the buffer full. The rising strobe then raises an interrupt request, provided the interrupt is enabled. In output mode, a processor write empties the buffer. A peripheral acknowledge marks it full again and raises the interrupt request if that is enabled. In every other mode the wide ports act as basic ports with no flags.

The timer flag is set by a one-cycle terminal-count pulse from outside. It clears as a side effect of reading the status byte.

Top module: `pario_unit`

## Requirements
- R1: Register selection uses only address bits 2:0: 0 is command (write) and status (read), 1 is wide port A, 2 is wide port B, 3 is narrow port C. Upper address bits have no effect. Reads at addresses 4 to 7 return 0.
- R2: While `rst_n` is low at a clock edge, the command register clears. After reset all ports are inputs (`pa_oe`, `pb_oe`, `pc_oe` low), every status flag reads 0, and `timer_cmd` is 0.
- R3: Status bit layout: bit0 port-A interrupt request, bit1 port-A buffer full, bit2 port-A interrupt enable, bit3 port-B interrupt request, bit4 port-B buffer full, bit5 port-B interrupt enable, bit6 timer flag. Bit7 always reads 0.
- R4: A `tc_pulse` sets the timer flag at the next edge. A status read clears it at the end of that read cycle. If a pulse and a status read fall in the same cycle, the flag stays set.
- R5: Command bit0 sets port A direction and bit1 sets port B direction, with 1 meaning output. An output port drives its written latch and reads it back.
- R6: Command bits 3:2 select the port C mode: 00 means input (no drivers, reads live pins), 01 means output (all six pins driven from a written latch), and 1x means handshake.
- R7: In handshake mode with port A or B set as input, a falling strobe (active low) latches the pins and sets buffer full. Later pin changes do not alter the value read.
- R8: The interrupt request of an input port rises on the strobe's rising edge only if buffer full is set and the enable bit is on. The enable for port A is command bit4 and for port B is command bit5.
- R9: A processor read of a strobed input port clears both its buffer full and interrupt request.
- R10: For a strobed output port, a processor write clears buffer full and interrupt request. The rising edge of the acknowledge strobe sets buffer full and, if enabled, the interrupt request.
- R11: In handshake mode, port C pin 0 drives A's interrupt request, pin 1 drives A's buffer full, and pin 2 is A's strobe input. Pins 3, 4 and 5 serve the same roles for B. `pc_oe` is 6'b011011.
- R12: Outside handshake mode the wide ports work in basic mode. An input read returns the live pins, and both flags of each port stay 0.
- R13: `timer_cmd` presents command bits 7:6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Bus address; only bits 2:0 decoded |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read; side effects at cycle end |
| rdata | output | 8 | Read data for the addressed register (combinational) |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A drive enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B drive enable |
| pc_in | input | 6 | Port C pin input (strobes in handshake mode) |
| pc_out | output | 6 | Port C output value |
| pc_oe | output | 6 | Port C per-pin drive enable |
| tc_pulse | input | 1 | Timer terminal-count pulse |
| timer_cmd | output | 2 | Timer command field of the command word |

## Verification
The bench aims at the edges of the strobe protocol. It changes the port pins while the strobe is still low and after its release. A design that latched data on the rising edge, or sampled continuously, would return the changed data. It runs strobes with the enable bit off. A design that ignored the enable would show an interrupt request in status bit0 or bit3 and on port C. A status read is placed in the same cycle as a timer pulse, and a design that lets the clear win would lose the event. Writes also go through aliased upper address bits, so a full-width decoder would miss them.

// File: rtl/pario_pkg.sv
// Package: shared field types and register selects for the parallel I/O unit.
// Assumes an 8-bit command word; field positions are fixed by the bus contract.
package pario_pkg;

    // Register selects on address bits 2:0
    localparam logic [2:0] SEL_CMD = 3'd0;
    localparam logic [2:0] SEL_PA  = 3'd1;
    localparam logic [2:0] SEL_PB  = 3'd2;
    localparam logic [2:0] SEL_PC  = 3'd3;

    // Port C mode field (command bits 3:2)
    typedef enum logic [1:0] {
        PCM_INPUT  = 2'b00,
        PCM_OUTPUT = 2'b01,
        PCM_HSK    = 2'b10,
        PCM_HSK_X  = 2'b11
    } pc_mode_e;

    // Decoded command word
    typedef struct packed {
        logic [1:0] tmr_cmd;  // bits 7:6
        logic       inte_b;   // bit 5
        logic       inte_a;   // bit 4
        pc_mode_e   pc_mode;  // bits 3:2
        logic       dir_b;    // bit 1, 1 = output
        logic       dir_a;    // bit 0, 1 = output
    } cmd_word_t;

endpackage

// File: rtl/pario_cmd_stat.sv
// Module: command register and timer flag.
// Holds the command word written at select 0 and the sticky timer flag.
// The flag sets on a terminal-count pulse and clears after a status read.
// A pulse in the same cycle as the read keeps the flag set.
// Assumes rd_sts and wr_cmd last one cycle per bus access.
module pario_cmd_stat
    import pario_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_cmd,
    input  logic      rd_sts,
    input  logic [7:0] wdata,
    input  logic      tc_pulse,
    output cmd_word_t cmd,
    output logic      tmr_flag
);

    // Command register: loaded on a write, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd <= '0;
        else if (wr_cmd)
            cmd <= cmd_word_t'(wdata);
    end

    // Timer flag: the set takes priority over the read clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            tmr_flag <= 1'b0;
        else if (tc_pulse)
            tmr_flag <= 1'b1;
        else if (rd_sts)
            tmr_flag <= 1'b0;
    end

    AST_TMR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> tmr_flag);                                  // R4
    AST_TMR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sts && !tc_pulse) |=> !tmr_flag);                    // R4

endmodule

// File: rtl/pario_port.sv
// Module: one wide parallel port with basic and strobed handshake modes.
// Input direction: a strobe fall latches the pins and sets buffer full, and
// the strobe rise raises the request if enabled. A bus read clears both flags.
// Output direction: a bus write clears both flags, and the acknowledge rise
// sets buffer full and raises the request if enabled.
// Assumes the strobe pin is already synchronous to clk.
module pario_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dir_out,
    input  logic         strobed,
    input  logic         inte,
    input  logic         wr,
    input  logic         rd,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_in,
    input  logic         stb_n,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] rd_val,
    output logic         bf,
    output logic         irq
);

    logic         stb_q;
    logic         stb_fall;
    logic         stb_rise;
    logic [W-1:0] in_hold;

    // Previous strobe level, used for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)
            stb_q <= 1'b1;
        else
            stb_q <= stb_n;
    end

    assign stb_fall = stb_q & ~stb_n;
    assign stb_rise = ~stb_q & stb_n;

    // Output latch: any bus write updates it
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_out <= '0;
        else if (wr)
            pin_out <= wdata;
    end

    // Input holding register: loads on a strobe fall in strobed input mode
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_hold <= '0;
        else if (strobed && !dir_out && stb_fall)
            in_hold <= pin_in;
    end

    // Handshake flags: buffer full and interrupt request
    always_ff @(posedge clk) begin
        if (!rst_n || !strobed) begin
            bf  <= 1'b0;
            irq <= 1'b0;
        end else if (!dir_out) begin
            if (rd) begin
                bf  <= 1'b0;
                irq <= 1'b0;
            end
            if (stb_fall)
                bf <= 1'b1;
            if (stb_rise && bf && inte && !rd)
                irq <= 1'b1;
        end else begin
            if (wr) begin
                bf  <= 1'b0;
                irq <= 1'b0;
            end
            if (stb_rise) begin
                bf <= 1'b1;
                if (inte)
                    irq <= 1'b1;
            end
        end
    end

    // Read value: the latch for output, the held or live pins for input
    always_comb begin
        if (dir_out)
            rd_val = pin_out;
        else if (strobed)
            rd_val = in_hold;
        else
            rd_val = pin_in;
    end

    AST_BF_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (strobed && !dir_out && stb_fall) |=> bf);               // R7
    AST_IRQ_NEEDS_INTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(inte));                             // R8
    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (strobed && !dir_out && rd && !stb_fall) |=> (!bf && !irq)); // R9
    AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (strobed && dir_out && wr && !stb_rise) |=> (!bf && !irq));  // R10
    AST_BASIC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !strobed |=> (!bf && !irq));                             // R12

endmodule

// File: rtl/pario_pc_mux.sv
// Module: narrow port C, which runs as plain input, plain output, or handshake lines.
// In handshake mode pins 0/1 drive A's request and buffer full, and pin 2 is A's
// strobe. Pins 3/4/5 do the same for B. The strobes always follow the live
// pins, so entering handshake mode creates no false edge.
module pario_pc_mux
    import pario_pkg::*;
#(
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pc_mode_e      mode,
    input  logic          wr,
    input  logic [PW-1:0] wdata,
    input  logic [PW-1:0] pc_in,
    input  logic          irq_a,
    input  logic          bf_a,
    input  logic          irq_b,
    input  logic          bf_b,
    output logic [PW-1:0] pc_out,
    output logic [PW-1:0] pc_oe,
    output logic [PW-1:0] rd_val,
    output logic          stb_a_n,
    output logic          stb_b_n,
    output logic          hsk
);

    localparam int HALF = 3;
    localparam logic [PW-1:0] HSK_OE = PW'(6'b011011);

    logic [PW-1:0] latch_q;

    // Port C output latch: loaded on a bus write
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (wr)
            latch_q <= wdata;
    end

    assign hsk     = mode[1];
    assign stb_a_n = pc_in[2];
    assign stb_b_n = pc_in[HALF + 2];

    // Pin drive values and enables for each mode
    always_comb begin
        pc_out = latch_q;
        pc_oe  = '0;
        unique case (mode)
            PCM_INPUT:  pc_oe = '0;
            PCM_OUTPUT: pc_oe = '1;
            default: begin
                pc_oe  = HSK_OE;
                pc_out = '0;
                pc_out[0]        = irq_a;
                pc_out[1]        = bf_a;
                pc_out[HALF]     = irq_b;
                pc_out[HALF + 1] = bf_b;
            end
        endcase
    end

    // Read value: driven pins read their output, the others read the pin
    always_comb begin
        for (int i = 0; i < PW; i++)
            rd_val[i] = pc_oe[i] ? pc_out[i] : pc_in[i];
    end

    AST_HSK_FLAGS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        hsk |-> (pc_out[1] == bf_a && pc_out[HALF+1] == bf_b));  // R11
    AST_PCIN_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PCM_INPUT) |-> (pc_oe == '0));                  // R6

endmodule

// File: rtl/pario_unit.sv
// Module: top of the parallel I/O unit. It decodes the bus, holds the two wide
// ports, port C and the command/status register, and builds the status byte.
// Assumes one-cycle rd_en/wr_en strobes. rdata is combinational for the
// current address, and read side effects take place at the end of the cycle.
module pario_unit
    import pario_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DW     = 8,
    parameter int PCW    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DW-1:0]     rdata,
    input  logic [DW-1:0]     pa_in,
    output logic [DW-1:0]     pa_out,
    output logic              pa_oe,
    input  logic [DW-1:0]     pb_in,
    output logic [DW-1:0]     pb_out,
    output logic              pb_oe,
    input  logic [PCW-1:0]    pc_in,
    output logic [PCW-1:0]    pc_out,
    output logic [PCW-1:0]    pc_oe,
    input  logic              tc_pulse,
    output logic [1:0]        timer_cmd
);

    localparam int NPORT = 2;

    logic [2:0]   sel;
    cmd_word_t    cmd;
    logic         tmr_flag;
    logic         hsk;
    logic         stb_a_n;
    logic         stb_b_n;
    logic [PCW-1:0] pc_rd;

    logic [NPORT-1:0]         p_dir;
    logic [NPORT-1:0]         p_inte;
    logic [NPORT-1:0]         p_wr;
    logic [NPORT-1:0]         p_rd;
    logic [NPORT-1:0]         p_stb;
    logic [NPORT-1:0]         p_bf;
    logic [NPORT-1:0]         p_irq;
    logic [NPORT-1:0][DW-1:0] p_in;
    logic [NPORT-1:0][DW-1:0] p_out;
    logic [NPORT-1:0][DW-1:0] p_rdv;

    assign sel = addr[2:0];

    pario_cmd_stat u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cmd   (wr_en && sel == SEL_CMD),
        .rd_sts   (rd_en && sel == SEL_CMD),
        .wdata    (wdata),
        .tc_pulse (tc_pulse),
        .cmd      (cmd),
        .tmr_flag (tmr_flag)
    );

    // Per-port wiring for the two wide ports
    assign p_dir  = {cmd.dir_b, cmd.dir_a};
    assign p_inte = {cmd.inte_b, cmd.inte_a};
    assign p_wr   = {wr_en && sel == SEL_PB, wr_en && sel == SEL_PA};
    assign p_rd   = {rd_en && sel == SEL_PB, rd_en && sel == SEL_PA};
    assign p_stb  = {stb_b_n, stb_a_n};
    assign p_in   = {pb_in, pa_in};

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        pario_port #(.W(DW)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .dir_out (p_dir[g]),
            .strobed (hsk),
            .inte    (p_inte[g]),
            .wr      (p_wr[g]),
            .rd      (p_rd[g]),
            .wdata   (wdata),
            .pin_in  (p_in[g]),
            .stb_n   (p_stb[g]),
            .pin_out (p_out[g]),
            .rd_val  (p_rdv[g]),
            .bf      (p_bf[g]),
            .irq     (p_irq[g])
        );
    end

    pario_pc_mux #(.PW(PCW)) u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (cmd.pc_mode),
        .wr      (wr_en && sel == SEL_PC),
        .wdata   (wdata[PCW-1:0]),
        .pc_in   (pc_in),
        .irq_a   (p_irq[0]),
        .bf_a    (p_bf[0]),
        .irq_b   (p_irq[1]),
        .bf_b    (p_bf[1]),
        .pc_out  (pc_out),
        .pc_oe   (pc_oe),
        .rd_val  (pc_rd),
        .stb_a_n (stb_a_n),
        .stb_b_n (stb_b_n),
        .hsk     (hsk)
    );

    assign pa_out    = p_out[0];
    assign pb_out    = p_out[1];
    assign pa_oe     = cmd.dir_a;
    assign pb_oe     = cmd.dir_b;
    assign timer_cmd = cmd.tmr_cmd;

    // Read mux: the status byte is built from the flags of both ports
    always_comb begin
        unique case (sel)
            SEL_CMD: rdata = {1'b0, tmr_flag, cmd.inte_b, p_bf[1], p_irq[1],
                              cmd.inte_a, p_bf[0], p_irq[0]};
            SEL_PA:  rdata = p_rdv[0];
            SEL_PB:  rdata = p_rdv[1];
            SEL_PC:  rdata = DW'(pc_rd);
            default: rdata = '0;
        endcase
    end

    AST_STS_BIT7_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_CMD) |-> !rdata[7]);                         // R3
    AST_HSK_IRQ_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        hsk |-> (pc_out[0] == rdata_irq_a_chk));                 // R11

    logic rdata_irq_a_chk;
    assign rdata_irq_a_chk = p_irq[0];

endmodule

// File: tb/test_pario_unit.sv
// Directed bench for pario_unit: one task per scenario, each checking its own results.
module test_pario_unit;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic       wr_en;
    logic       rd_en;
    logic [7:0] rdata;
    logic [7:0] pa_in, pa_out, pb_in, pb_out;
    logic       pa_oe, pb_oe;
    logic [5:0] pc_in, pc_out, pc_oe;
    logic       tc_pulse;
    logic [1:0] timer_cmd;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [5:0] PC_IDLE = 6'b100100;

    always #2 clk = ~clk;

    pario_unit i_pario_unit (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
        .tc_pulse(tc_pulse), .timer_cmd(timer_cmd)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_pc(input int bitn, input logic v);
        @(negedge clk);
        pc_in[bitn] = v;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        bus_rd(8'h00, d);
        check("R2 status", d, 8'h00);
        check("R2 oe", {pa_oe, pb_oe, pc_oe}, 8'h00);
        check("R2 timer_cmd", {6'd0, timer_cmd}, 8'h00);
    endtask

    task automatic t_decode_dir;
        logic [7:0] d;
        bus_wr(8'hF8, 8'h03);                    // R1 aliased command address
        check("R5 dir oe", {6'd0, pa_oe, pb_oe}, 8'h03);
        bus_wr(8'h21, 8'hA5);
        check("R1 R5 pa_out", pa_out, 8'hA5);
        bus_wr(8'h6A, 8'h3C);
        bus_rd(8'hCA, d);
        check("R1 R5 pb readback", d, 8'h3C);
        bus_rd(8'h05, d);
        check("R1 unused select", d, 8'h00);
    endtask

    task automatic t_basic;
        logic [7:0] d;
        bus_wr(8'h00, 8'h00);
        @(negedge clk); pa_in = 8'h5A;
        bus_rd(8'h01, d);
        check("R12 live pins", d, 8'h5A);
        @(negedge clk); pa_in = 8'h11;
        bus_rd(8'h01, d);
        check("R12 live pins 2", d, 8'h11);
        set_pc(2, 1'b0); set_pc(2, 1'b1);        // strobe ignored in basic mode
        bus_rd(8'h00, d);
        check("R12 no flags", d, 8'h00);
        bus_rd(8'h03, d);
        check("R6 pc input read", d, {2'b00, PC_IDLE});
        check("R6 pc input oe", {2'b00, pc_oe}, 8'h00);
    endtask

    task automatic t_pc_out;
        logic [7:0] d;
        bus_wr(8'h00, 8'h04);
        bus_wr(8'h03, 8'h2A);
        check("R6 pc oe", {2'b00, pc_oe}, 8'h3F);
        check("R6 pc out", {2'b00, pc_out}, 8'h2A);
        bus_rd(8'h03, d);
        check("R6 pc readback", d, 8'h2A);
    endtask

    task automatic t_strobe_in;
        logic [7:0] d;
        bus_wr(8'h00, 8'h18);                    // hsk, port A input, inte A
        check("R11 hsk oe", {2'b00, pc_oe}, 8'h1B);
        @(negedge clk); pa_in = 8'hC3;
        set_pc(2, 1'b0);
        @(negedge clk); pa_in = 8'h00;           // change while strobe low
        bus_rd(8'h00, d);
        check("R7 R3 bf only", d, 8'h06);
        check("R11 bf pin", {7'd0, pc_out[1]}, 8'h01);
        set_pc(2, 1'b1);
        bus_rd(8'h00, d);
        check("R8 R3 irq A", d, 8'h07);
        check("R11 irq pin", {7'd0, pc_out[0]}, 8'h01);
        bus_rd(8'h01, d);
        check("R7 held data", d, 8'hC3);
        bus_rd(8'h00, d);
        check("R9 read clears", d, 8'h04);
    endtask

    task automatic t_no_inte;
        logic [7:0] d;
        bus_wr(8'h00, 8'h08);                    // hsk, no enables
        @(negedge clk); pb_in = 8'h77;
        set_pc(5, 1'b0); set_pc(5, 1'b1);
        bus_rd(8'h00, d);
        check("R8 no irq without inte", d, 8'h10);
        check("R11 B pins", {5'd0, pc_out[5:3]}, 8'h02);
        bus_rd(8'h02, d);
        check("R7 B held", d, 8'h77);
        bus_rd(8'h00, d);
        check("R9 B cleared", d, 8'h00);
    endtask

    task automatic t_strobe_out;
        logic [7:0] d;
        bus_wr(8'h00, 8'h2B);                    // both out, hsk, inte B
        set_pc(5, 1'b0); set_pc(5, 1'b1);        // acknowledge B
        bus_rd(8'h00, d);
        check("R10 ack sets", d, 8'h38);
        check("R11 B pins out", {5'd0, pc_out[5:3]}, 8'h03);
        bus_wr(8'h02, 8'h99);
        bus_rd(8'h00, d);
        check("R10 write clears", d, 8'h20);
        check("R10 data out", pb_out, 8'h99);
    endtask

    task automatic t_timer;
        logic [7:0] d;
        bus_wr(8'h00, 8'h00);
        @(negedge clk); tc_pulse = 1'b1;
        @(negedge clk); tc_pulse = 1'b0;
        bus_rd(8'h00, d);
        check("R4 R3 flag set", d, 8'h40);
        bus_rd(8'h00, d);
        check("R4 cleared by read", d, 8'h00);
        @(negedge clk); addr = 8'h00; rd_en = 1'b1; tc_pulse = 1'b1;
        @(negedge clk); rd_en = 1'b0; tc_pulse = 1'b0;
        bus_rd(8'h00, d);
        check("R4 pulse wins", d, 8'h40);
    endtask

    task automatic t_tcmd;
        logic [7:0] d;
        bus_wr(8'h00, 8'hF8);                    // all enables, hsk, timer cmd 3
        check("R13 timer_cmd", {6'd0, timer_cmd}, 8'h03);
        @(negedge clk); tc_pulse = 1'b1;
        @(negedge clk); tc_pulse = 1'b0;
        bus_rd(8'h00, d);
        check("R3 bit7 zero", {7'd0, d[7]}, 8'h00);
        check("R3 enables", d, 8'h64);
    endtask

    initial begin
        rst_n = 1'b0; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
        pa_in = '0; pb_in = '0; pc_in = PC_IDLE; tc_pulse = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_decode_dir();
        t_basic();
        t_pc_out();
        t_strobe_in();
        t_no_inte();
        t_strobe_out();
        t_timer();
        t_tcmd();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule